// File: doc/BRIEF.md
# Serial Audio Link Output Frame Receiver

This block sits on the codec side of a serial audio link and turns the controller's outgoing bit stream into parallel words. It runs on the falling edge of the link bit clock. A rising edge of the frame sync line starts a frame. The bits that follow are collected into a 16-bit tag slot and then twelve 20-bit slots. From the tag slot and the first two data slots it works out whether the frame carries a register command addressed to this codec. If it does, the command goes out as a one-cycle strobe with a read/write flag, a register index and write data. The ten audio slots are presented as words, and a valid flag for each one is updated when the frame ends.

A two-bit configuration input sets the codec's role. Zero makes it the primary codec, which relies on the command tag bits. Any non-zero value makes it a secondary codec, which treats a matching ID in the tag slot as its command-valid indicator. In either role, a frame whose frame-valid bit is clear produces no command and no audio flags. If a new sync edge arrives before a frame is complete, the receiver starts over, and the cut-short frame raises no frame-done.

Top module: `ac_link_frame_rx`

## Requirements
- R1: A rising edge on `sync` is detected on a falling edge of `bitClk`. The bit sampled on the next falling edge is tag-slot bit 15 (frame valid), and every later bit is sampled on the falling edge that follows its launch.
- R2: A frame is a 16-bit tag slot followed by twelve 20-bit slots, each sent MSB first. `frameDone` pulses for exactly one bit-clock cycle, starting at the falling edge that samples the 256th bit.
- R3: When tag bit 15 is clear, no command strobe is raised and `pcmValid` is all zeros at that frame's `frameDone`, whatever the ID field and tag bits hold.
- R4: With `myId` = 00, a command is accepted only if tag bits 1:0 are 00 and tag bit 14 is set. A write also needs tag bit 13.
- R5: With a non-zero `myId`, a command is accepted when tag bits 1:0 equal `myId`. Tag bits 14 and 13 are ignored, and a frame carrying any other ID value gives no command.
- R6: Slot 1 bit 19 gives the direction (1 = read) and slot 1 bits 18:12 give `cmdAddr`. `cmdData` is slot 2 bits 19:4. `cmdStrobe` is high for one bit-clock cycle, starting at the falling edge that samples the last bit of slot 2.
- R7: Slot k (k = 3..12) appears on `pcmWord[k-3]`. Its flag `pcmValid[k-3]` is taken from tag bit 15-k and is updated only at `frameDone`.
- R8: A `sync` rising edge before all 256 bits have arrived drops the partial frame: no `frameDone` is raised and `pcmValid` keeps its value. The receiver then decodes the new frame normally.
- R9: While `rstN` is low, `cmdStrobe`, `frameDone`, `cmdRead`, `cmdAddr`, `cmdData` and `pcmValid` are all zero.
- R10: A primary codec ignores any frame whose tag bits 1:0 are non-zero, even with tag bits 14 and 13 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bitClk | input | 1 | Link bit clock; the receiver samples on its falling edge |
| rstN | input | 1 | Active-low asynchronous reset |
| sync | input | 1 | Frame sync; a rising edge starts a frame |
| sdataOut | input | 1 | Serial data from the controller |
| myId | input | 2 | Codec ID; 00 = primary, otherwise secondary |
| cmdStrobe | output | 1 | One-cycle pulse marking an accepted command |
| cmdRead | output | 1 | 1 = read, 0 = write; valid with cmdStrobe |
| cmdAddr | output | 7 | Register index of the command |
| cmdData | output | 16 | Write data of the command |
| pcmWord | output | 10x20 | Audio slot words; index 0 is slot 3 |
| pcmValid | output | 10 | Valid flags for the audio words, updated at frameDone |
| frameDone | output | 1 | One-cycle pulse after a complete frame |

## Verification
A slot or bit counter that is off by one in the receiver moves every field. It shows up within a single frame as a wrong register index or data value, and the tag bits land in the wrong places, so commands appear or vanish. A counter that fails to reset on sync would let a cut-short frame raise `frameDone` or change `pcmValid`, and the next frame would then decode incorrectly. If the ID or tag decode keeps a stale or wrong value, it shows up as a command strobe in the wrong role or on an invalid frame, visible at the end of slot 2 of that same frame.

// File: rtl/acrx_pkg.sv
package acrx_pkg;
  parameter int TAG_BITS  = 16;
  parameter int WORD_BITS = 20;
  parameter int SLOTS     = 13;
  parameter int IDX_W     = $clog2(SLOTS);

  typedef struct packed {
    logic             sample;
    logic             slotEnd;
    logic [IDX_W-1:0] slotIdx;
    logic             frameEnd;
  } strobe_t;
endpackage

// File: rtl/acrx_ctrl.sv
module acrx_ctrl
  import acrx_pkg::*;
#(
  parameter int SLOT0_BITS = TAG_BITS,
  parameter int SLOT_BITS  = WORD_BITS,
  parameter int NUM_SLOTS  = SLOTS
) (
  input  logic    bitClk,
  input  logic    rstN,
  input  logic    sync,
  output strobe_t stb
);
  localparam int CNT_W = $clog2(SLOT_BITS);

  logic             syncPrev;
  logic             active;
  logic [IDX_W-1:0] slotIdx;
  logic [CNT_W-1:0] bitInSlot;
  logic [CNT_W-1:0] lastBit;
  logic             syncRise;
  logic             slotEnd;
  logic             frameEnd;

  assign syncRise = sync & ~syncPrev;
  assign lastBit  = (slotIdx == '0) ? CNT_W'(SLOT0_BITS - 1) : CNT_W'(SLOT_BITS - 1);
  assign slotEnd  = active && (bitInSlot == lastBit);
  assign frameEnd = slotEnd && (slotIdx == IDX_W'(NUM_SLOTS - 1));

  always_comb begin
    stb.sample   = active;
    stb.slotEnd  = slotEnd;
    stb.slotIdx  = slotIdx;
    stb.frameEnd = frameEnd;
  end

  always_ff @(negedge bitClk or negedge rstN) begin
    if (!rstN) begin
      syncPrev  <= 1'b0;
      active    <= 1'b0;
      slotIdx   <= '0;
      bitInSlot <= '0;
    end else begin
      syncPrev <= sync;
      if (syncRise) begin
        active    <= 1'b1;
        slotIdx   <= '0;
        bitInSlot <= '0;
      end else if (frameEnd) begin
        active <= 1'b0;
      end else if (slotEnd) begin
        slotIdx   <= slotIdx + 1'b1;
        bitInSlot <= '0;
      end else if (active) begin
        bitInSlot <= bitInSlot + 1'b1;
      end
    end
  end

  // R1
  restart_chk: assert property (@(negedge bitClk) disable iff (!rstN)
    syncRise |=> (active && slotIdx == '0 && bitInSlot == '0));

  // R2
  slot_bound_chk: assert property (@(negedge bitClk) disable iff (!rstN)
    active |-> (bitInSlot <= lastBit && slotIdx <= IDX_W'(NUM_SLOTS - 1)));

  // R2
  frame_stop_chk: assert property (@(negedge bitClk) disable iff (!rstN)
    (frameEnd && !syncRise) |=> !active);
endmodule

// File: rtl/acrx_datapath.sv
module acrx_datapath
  import acrx_pkg::*;
#(
  parameter int SLOT0_BITS = TAG_BITS,
  parameter int SLOT_BITS  = WORD_BITS,
  parameter int NUM_SLOTS  = SLOTS,
  parameter int ADDR_BITS  = 7,
  parameter int DATA_BITS  = 16,
  parameter int ID_BITS    = 2
) (
  input  logic                                  bitClk,
  input  logic                                  rstN,
  input  logic                                  sdata,
  input  logic [ID_BITS-1:0]                    myId,
  input  strobe_t                               stb,
  output logic                                  cmdStrobe,
  output logic                                  cmdRead,
  output logic [ADDR_BITS-1:0]                  cmdAddr,
  output logic [DATA_BITS-1:0]                  cmdData,
  output logic [NUM_SLOTS-4:0][SLOT_BITS-1:0]   pcmWord,
  output logic [NUM_SLOTS-4:0]                  pcmValid,
  output logic                                  frameDone
);
  localparam int NPCM   = NUM_SLOTS - 3;
  localparam int TAG_W  = NPCM + 3;
  localparam int FV     = TAG_W - 1;
  localparam int ATAG   = TAG_W - 2;
  localparam int DTAG   = TAG_W - 3;

  logic [SLOT_BITS-2:0] shiftQ;
  logic [SLOT_BITS-1:0] nextWord;
  logic [TAG_W-1:0]     s0Tags;
  logic [ID_BITS-1:0]   s0Id;
  logic [ADDR_BITS:0]   hdrQ;
  logic [NPCM-1:0]      tagFlags;
  logic                 isRead, primaryHit, secondaryHit, cmdHit, slot2End;

  assign nextWord = {shiftQ, sdata};
  assign isRead   = hdrQ[ADDR_BITS];
  assign slot2End = stb.slotEnd && (stb.slotIdx == IDX_W'(2));

  always_comb begin
    for (int g = 0; g < NPCM; g++) tagFlags[g] = s0Tags[NPCM-1-g];
    primaryHit   = (myId == '0) && (s0Id == '0) && s0Tags[ATAG] && (isRead || s0Tags[DTAG]);
    secondaryHit = (myId != '0) && (s0Id == myId);
    cmdHit       = s0Tags[FV] && (primaryHit || secondaryHit);
  end

  always_ff @(negedge bitClk or negedge rstN) begin
    if (!rstN) begin
      shiftQ    <= '0;
      s0Tags    <= '0;
      s0Id      <= '0;
      hdrQ      <= '0;
      cmdStrobe <= 1'b0;
      cmdRead   <= 1'b0;
      cmdAddr   <= '0;
      cmdData   <= '0;
      pcmWord   <= '0;
      pcmValid  <= '0;
      frameDone <= 1'b0;
    end else begin
      if (stb.sample) shiftQ <= nextWord[SLOT_BITS-2:0];
      if (stb.slotEnd && stb.slotIdx == '0) begin
        s0Tags <= nextWord[SLOT0_BITS-1 -: TAG_W];
        s0Id   <= nextWord[ID_BITS-1:0];
      end
      if (stb.slotEnd && stb.slotIdx == IDX_W'(1))
        hdrQ <= nextWord[SLOT_BITS-1 -: ADDR_BITS+1];
      cmdStrobe <= slot2End && cmdHit;
      if (slot2End && cmdHit) begin
        cmdRead <= isRead;
        cmdAddr <= hdrQ[ADDR_BITS-1:0];
        cmdData <= nextWord[SLOT_BITS-1 -: DATA_BITS];
      end
      for (int g = 0; g < NPCM; g++)
        if (stb.slotEnd && stb.slotIdx == IDX_W'(g + 3)) pcmWord[g] <= nextWord;
      frameDone <= stb.frameEnd;
      if (stb.frameEnd) pcmValid <= s0Tags[FV] ? tagFlags : '0;
    end
  end

  // R3
  frame_valid_gate_chk: assert property (@(negedge bitClk) disable iff (!rstN)
    cmdStrobe |-> s0Tags[FV]);

  // R3
  flags_need_valid_chk: assert property (@(negedge bitClk) disable iff (!rstN)
    (frameDone && pcmValid != '0) |-> s0Tags[FV]);

  // R5
  secondary_id_chk: assert property (@(negedge bitClk) disable iff (!rstN)
    (cmdStrobe && myId != '0) |-> (s0Id == myId));

  // R4
  primary_tag_chk: assert property (@(negedge bitClk) disable iff (!rstN)
    (cmdStrobe && myId == '0) |-> (s0Id == '0 && s0Tags[ATAG] && (cmdRead || s0Tags[DTAG])));

  // R6
  cmd_pulse_chk: assert property (@(negedge bitClk) disable iff (!rstN)
    cmdStrobe |=> !cmdStrobe);

  // R2
  done_pulse_chk: assert property (@(negedge bitClk) disable iff (!rstN)
    frameDone |=> !frameDone);

  // R7
  flags_hold_chk: assert property (@(negedge bitClk) disable iff (!rstN)
    !frameDone |-> $stable(pcmValid));
endmodule

// File: rtl/ac_link_frame_rx.sv
module ac_link_frame_rx
  import acrx_pkg::*;
#(
  parameter int SLOT0_BITS = TAG_BITS,
  parameter int SLOT_BITS  = WORD_BITS,
  parameter int NUM_SLOTS  = SLOTS,
  parameter int ADDR_BITS  = 7,
  parameter int DATA_BITS  = 16,
  parameter int ID_BITS    = 2
) (
  input  logic                                bitClk,
  input  logic                                rstN,
  input  logic                                sync,
  input  logic                                sdataOut,
  input  logic [ID_BITS-1:0]                  myId,
  output logic                                cmdStrobe,
  output logic                                cmdRead,
  output logic [ADDR_BITS-1:0]                cmdAddr,
  output logic [DATA_BITS-1:0]                cmdData,
  output logic [NUM_SLOTS-4:0][SLOT_BITS-1:0] pcmWord,
  output logic [NUM_SLOTS-4:0]                pcmValid,
  output logic                                frameDone
);
  strobe_t stb;

  acrx_ctrl #(
    .SLOT0_BITS(SLOT0_BITS), .SLOT_BITS(SLOT_BITS), .NUM_SLOTS(NUM_SLOTS)
  ) uCtrl (
    .bitClk(bitClk), .rstN(rstN), .sync(sync), .stb(stb)
  );

  acrx_datapath #(
    .SLOT0_BITS(SLOT0_BITS), .SLOT_BITS(SLOT_BITS), .NUM_SLOTS(NUM_SLOTS),
    .ADDR_BITS(ADDR_BITS), .DATA_BITS(DATA_BITS), .ID_BITS(ID_BITS)
  ) uData (
    .bitClk(bitClk), .rstN(rstN), .sdata(sdataOut), .myId(myId), .stb(stb),
    .cmdStrobe(cmdStrobe), .cmdRead(cmdRead), .cmdAddr(cmdAddr), .cmdData(cmdData),
    .pcmWord(pcmWord), .pcmValid(pcmValid), .frameDone(frameDone)
  );
endmodule

// File: tb/sim_ac_link_frame_rx.sv
`timescale 1ns/1ps
module sim_ac_link_frame_rx;
  logic              bitClk = 1'b0;
  logic              rstN = 1'b0;
  logic              sync = 1'b0;
  logic              sdataOut = 1'b0;
  logic [1:0]        myId = 2'b00;
  logic              cmdStrobe, cmdRead, frameDone;
  logic [6:0]        cmdAddr;
  logic [15:0]       cmdData;
  logic [9:0][19:0]  pcmWord;
  logic [9:0]        pcmValid;

  int checks = 0;
  int errors = 0;
  int cmdCount = 0;
  int doneCount = 0;
  logic        capRead;
  logic [6:0]  capAddr;
  logic [15:0] capData;
  logic [9:0][19:0] capPcm;
  logic [9:0]  capValid;

  always #4 bitClk = ~bitClk;

  ac_link_frame_rx u0 (
    .bitClk(bitClk), .rstN(rstN), .sync(sync), .sdataOut(sdataOut), .myId(myId),
    .cmdStrobe(cmdStrobe), .cmdRead(cmdRead), .cmdAddr(cmdAddr), .cmdData(cmdData),
    .pcmWord(pcmWord), .pcmValid(pcmValid), .frameDone(frameDone)
  );

  always @(posedge bitClk) begin
    if (cmdStrobe) begin
      cmdCount++;
      capRead = cmdRead; capAddr = cmdAddr; capData = cmdData;
    end
    if (frameDone) begin
      doneCount++;
      capPcm = pcmWord; capValid = pcmValid;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] pcmExp(input logic [19:0] seed, input int k);
    return seed + 20'(k * 32'h1357);
  endfunction

  function automatic logic [9:0] flagsExp(input logic [15:0] s0);
    logic [9:0] f;
    for (int g = 0; g < 10; g++) f[g] = s0[15] & s0[12-g];
    return f;
  endfunction

  task automatic sendFrame(input logic [15:0] s0, input logic [19:0] s1, input logic [19:0] s2,
                           input logic [19:0] seed, input int nBits);
    logic [255:0] fr;
    fr = '0;
    fr[255 -: 16] = s0;
    fr[239 -: 20] = s1;
    fr[219 -: 20] = s2;
    for (int k = 3; k <= 12; k++) fr[255 - 16 - 20*(k-1) -: 20] = pcmExp(seed, k);
    @(posedge bitClk); sync = 1'b1;
    for (int i = 0; i < nBits; i++) begin
      @(posedge bitClk);
      sdataOut = fr[255 - i];
      if (i == 15) sync = 1'b0;
    end
    @(posedge bitClk); sdataOut = 1'b0; sync = 1'b0;
    @(posedge bitClk);
  endtask

  // R4 R6 R7 R1 R2: primary write with audio
  task automatic tPrimaryWrite();
    int c0 = cmdCount, d0 = doneCount;
    logic [15:0] s0 = 16'hE000 | 16'h1000 | 16'h0400 | 16'h0008;
    myId = 2'b00;
    sendFrame(s0, {1'b0, 7'h2A, 12'h000}, {16'hBEEF, 4'h0}, 20'h12345, 256);
    check(cmdCount == c0 + 1, "R4 primary write accepted", cmdCount - c0, 1);
    check(capRead == 1'b0, "R6 write direction", capRead, 0);
    check(capAddr == 7'h2A, "R6 address", capAddr, 7'h2A);
    check(capData == 16'hBEEF, "R6 write data", capData, 16'hBEEF);
    check(doneCount == d0 + 1, "R2 one frameDone per frame", doneCount - d0, 1);
    check(capValid == flagsExp(s0), "R7 valid flags mapping", capValid, flagsExp(s0));
    for (int g = 0; g < 10; g++)
      check(capPcm[g] == pcmExp(20'h12345, g + 3), "R7 R2 audio word", capPcm[g], pcmExp(20'h12345, g + 3));
  endtask

  // R4 R6: primary read needs only the address tag
  task automatic tPrimaryRead();
    int c0 = cmdCount;
    sendFrame(16'hC000, {1'b1, 7'h7F, 12'hFFF}, 20'h0, 20'h0, 256);
    check(cmdCount == c0 + 1, "R4 primary read accepted", cmdCount - c0, 1);
    check(capRead == 1'b1 && capAddr == 7'h7F, "R6 read fields", {capRead, capAddr}, {1'b1, 7'h7F});
  endtask

  // R4: write without data tag is dropped
  task automatic tPrimaryNoData();
    int c0 = cmdCount;
    sendFrame(16'hC000, {1'b0, 7'h11, 12'h0}, {16'h1234, 4'h0}, 20'h0, 256);
    check(cmdCount == c0, "R4 write without data tag", cmdCount - c0, 0);
  endtask

  // R10: primary ignores non-zero ID
  task automatic tPrimaryOtherId();
    int c0 = cmdCount;
    sendFrame(16'hE001, {1'b0, 7'h05, 12'h0}, {16'h5555, 4'h0}, 20'h0, 256);
    check(cmdCount == c0, "R10 primary ignores secondary ID", cmdCount - c0, 0);
  endtask

  // R3: invalid frame with tags and audio flags
  task automatic tInvalidFrame();
    int c0 = cmdCount, d0 = doneCount;
    sendFrame(16'h7FF8, {1'b1, 7'h03, 12'h0}, 20'h0, 20'h0AAAA, 256);
    check(cmdCount == c0, "R3 no command on invalid frame", cmdCount - c0, 0);
    check(doneCount == d0 + 1 && capValid == 10'h000, "R3 flags cleared on invalid frame", capValid, 0);
  endtask

  // R5: secondary matching ID, tag bits clear
  task automatic tSecondary();
    int c0;
    myId = 2'b10;
    c0 = cmdCount;
    sendFrame(16'h8002, {1'b0, 7'h40, 12'h0}, {16'hCAFE, 4'h0}, 20'h0, 256);
    check(cmdCount == c0 + 1, "R5 secondary ID match", cmdCount - c0, 1);
    check(capAddr == 7'h40 && capData == 16'hCAFE, "R5 R6 secondary fields", {capAddr, capData}, {7'h40, 16'hCAFE});
    c0 = cmdCount;
    sendFrame(16'hE001, {1'b0, 7'h41, 12'h0}, {16'h0001, 4'h0}, 20'h0, 256);
    check(cmdCount == c0, "R5 secondary other ID", cmdCount - c0, 0);
    c0 = cmdCount;
    sendFrame(16'hE000, {1'b1, 7'h42, 12'h0}, 20'h0, 20'h0, 256);
    check(cmdCount == c0, "R5 secondary ignores primary command", cmdCount - c0, 0);
    c0 = cmdCount;
    sendFrame(16'h0002, {1'b1, 7'h43, 12'h0}, 20'h0, 20'h0, 256);
    check(cmdCount == c0, "R3 secondary invalid frame", cmdCount - c0, 0);
    myId = 2'b00;
  endtask

  // R8: cut-short frame then a full one
  task automatic tPartial();
    int d0;
    logic [15:0] sA = 16'h9800;
    logic [15:0] sC = 16'h8208;
    sendFrame(sA, 20'h0, 20'h0, 20'h00100, 256);
    check(pcmValid == flagsExp(sA), "R7 flags after full frame", pcmValid, flagsExp(sA));
    d0 = doneCount;
    sendFrame(16'h9FF9, 20'h0, 20'h0, 20'h00200, 120);
    check(doneCount == d0, "R8 no frameDone for partial frame", doneCount - d0, 0);
    check(pcmValid == flagsExp(sA), "R8 flags kept after partial frame", pcmValid, flagsExp(sA));
    sendFrame(sC, 20'h0, 20'h0, 20'h00300, 256);
    check(doneCount == d0 + 1, "R8 resync frame completes", doneCount - d0, 1);
    check(capValid == flagsExp(sC), "R8 resync frame flags", capValid, flagsExp(sC));
    check(capPcm[9] == pcmExp(20'h00300, 12), "R8 resync last slot", capPcm[9], pcmExp(20'h00300, 12));
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #200;
    @(posedge bitClk);
    check(cmdStrobe == 0 && frameDone == 0 && pcmValid == 0 && cmdAddr == 0 && cmdData == 0 && cmdRead == 0,
          "R9 reset state", {cmdStrobe, frameDone, pcmValid}, 0);
    rstN = 1'b1;
    repeat (4) @(posedge bitClk);
    tPrimaryWrite();
    tPrimaryRead();
    tPrimaryNoData();
    tPrimaryOtherId();
    tInvalidFrame();
    tSecondary();
    tPartial();
    finishRun();
  end

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finishRun();
  end
endmodule